// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the configuration byte of a serial memory's status register and decides whether a request to rewrite that byte is accepted. The byte holds a protect-enable bit, a volatile flag, a two-bit watchdog period code and a two-bit block-lock code. The byte also reports two live bits: the write-enable latch and a write-in-progress indication. The serial front end hands the block decoded strobes and data. Programming time is not modelled here. An external busy input stands in for it, and it decides when an accepted write lands in the register.

The active-low write-protect pin and the protect-enable bit together form a one-way lock. Once the protect-enable bit is 1 and the pin is low, every later status write is refused until the pin is raised again. A write that was accepted before the pin dropped still finishes. The block also decodes the block-lock code into an inclusive address pair, which the array write path compares with each byte address. It decodes the watchdog code into a period limit in ticks.

Top module: `stat_guard`

## Requirements
- R1: After reset, sr_value reads 0x30: watchdog code 11, block-lock 00, protect-enable 0, flag 0, write-enable latch 0, write-in-progress 0 while nv_busy is low. In that state prot_en is 0 and wdog_off is 1.
- R2: A cycle with wren high and sr_wr low sets the write-enable latch, reported on wel and in sr_value bit 1. Any cycle with sr_wr high clears the latch, whether or not the write is accepted.
- R3: A status write is accepted when all of these hold: the latch is set, no write is pending, nv_busy is low, data bits 1:0 are 00, and the lock is not active. An accepted write copies data bit 7 (protect-enable), bits 5:4 (watchdog code) and bits 3:2 (block-lock code) into the same positions of sr_value. The copy becomes visible in the cycle after the first falling edge of nv_busy that follows acceptance. At no other time do these bits change.
- R4: While wp_n is low and sr_value bit 7 is 1, a status write is refused and sr_value bits 7 and 5:2 keep their values.
- R5: While sr_value bit 7 is 0, the level of wp_n has no effect on whether a status write is accepted.
- R6: Driving wp_n low while an accepted write is pending does not abort that write. It still commits.
- R7: A status write whose data bits 1:0 are not 00 is refused.
- R8: A status write is refused while nv_busy is high or an earlier accepted write is still pending.
- R9: flag_set raises the flag (sr_value bit 6) on the next cycle and flag_clr lowers it. When both strobes are high, clear wins. A status write never changes the flag, whatever its data bit 6.
- R10: When the block-lock code is 00, prot_en, prot_lo and prot_hi are all 0. Otherwise prot_en is 1, prot_hi is the top address 2^ADDR_W-1, and prot_lo is three quarters of the space for code 01, half of the space for code 10, and 0 for code 11.
- R11: wdog_code equals sr_value bits 5:4. wdog_limit is PERIOD0, PERIOD1 or PERIOD2 for codes 00, 01 and 10. Code 11 gives wdog_off 1 and wdog_limit 0.
- R12: sr_value bit 0 is high whenever an accepted write is pending or nv_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren | input | 1 | Set the write-enable latch |
| sr_wr | input | 1 | Status write strobe |
| sr_wdata | input | 8 | Status write data byte |
| flag_set | input | 1 | Raise the flag latch |
| flag_clr | input | 1 | Lower the flag latch |
| wp_n | input | 1 | Write-protect pin, active low |
| nv_busy | input | 1 | Nonvolatile programming in progress |
| sr_value | output | 8 | Status register readback |
| wel | output | 1 | Write-enable latch |
| prot_en | output | 1 | Protected range is valid |
| prot_lo | output | ADDR_W | Lowest protected address |
| prot_hi | output | ADDR_W | Highest protected address |
| wdog_code | output | 2 | Selected watchdog period code |
| wdog_off | output | 1 | Watchdog disabled |
| wdog_limit | output | CNT_W | Watchdog period in ticks |

## Verification
The bench builds the block with ADDR_W=10, CNT_W=8 and periods of 140, 60 and 20 ticks. The address-range outputs therefore move away from their defaults: the three-quarter and half boundaries are 0x300 and 0x200, and a hard-wired twelve-bit constant would show up as a mismatch. The small period values fit the narrower limit output, so the bench checks every watchdog code against an exact count. Because it toggles nv_busy and wp_n at random while writes are pending, the bench reaches the case where the pin drops between acceptance and commit, and the case where a new write arrives during programming.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;

    localparam logic [1:0] WD_DISABLED = 2'b11;
    localparam logic [1:0] BL_NONE     = 2'b00;

    typedef struct packed {
        logic       wpen;
        logic [1:0] wd;
        logic [1:0] bl;
    } nv_fields_t;

    typedef struct packed {
        logic       wel;
        logic       pend;
        logic       seen;
        nv_fields_t stage;
    } ctl_state_t;

    typedef struct packed {
        nv_fields_t nv;
        logic       flag;
    } reg_state_t;

    localparam nv_fields_t NV_RESET = '{wpen: 1'b0, wd: WD_DISABLED, bl: BL_NONE};

    function automatic nv_fields_t nv_from_byte(input logic [7:0] b);
        nv_fields_t f;
        f.wpen = b[7];
        f.wd   = b[5:4];
        f.bl   = b[3:2];
        return f;
    endfunction

    function automatic logic [7:0] sr_pack(input nv_fields_t f, input logic flag,
                                           input logic wel, input logic wip);
        return {f.wpen, flag, f.wd, f.bl, wel, wip};
    endfunction

endpackage

// File: rtl/stat_guard_wrctl.sv
module stat_guard_wrctl
    import stat_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wren,
    input  logic       sr_wr,
    input  nv_fields_t wr_fields,
    input  logic [1:0] wr_low,
    input  logic       wp_n,
    input  logic       nv_busy,
    input  logic       cur_wpen,
    output logic       wel,
    output logic       pend,
    output logic       seen,
    output logic       commit,
    output nv_fields_t stage
);

    ctl_state_t st_d, st_q;
    logic locked;
    logic busy_any;
    logic data_ok;
    logic accept;
    logic finish;

    always_comb begin
        locked   = !wp_n && cur_wpen;
        busy_any = nv_busy || st_q.pend;
        data_ok  = (wr_low == 2'b00);
        accept   = sr_wr && st_q.wel && !busy_any && !locked && data_ok;
        finish   = st_q.pend && st_q.seen && !nv_busy;

        st_d = st_q;

        if (sr_wr) begin
            st_d.wel = 1'b0;
        end else if (wren) begin
            st_d.wel = 1'b1;
        end

        if (accept) begin
            st_d.pend  = 1'b1;
            st_d.seen  = 1'b0;
            st_d.stage = wr_fields;
        end else if (finish) begin
            st_d.pend = 1'b0;
            st_d.seen = 1'b0;
        end else if (st_q.pend && nv_busy) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wel: 1'b0, pend: 1'b0, seen: 1'b0, stage: NV_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    assign wel    = st_q.wel;
    assign pend   = st_q.pend;
    assign seen   = st_q.seen;
    assign commit = finish;
    assign stage  = st_q.stage;

endmodule

// File: rtl/stat_guard_regs.sv
module stat_guard_regs
    import stat_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    input  nv_fields_t stage,
    input  logic       flag_set,
    input  logic       flag_clr,
    output nv_fields_t nv,
    output logic       flag
);

    reg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (commit) begin
            r_d.nv = stage;
        end
        if (flag_clr) begin
            r_d.flag = 1'b0;
        end else if (flag_set) begin
            r_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{nv: NV_RESET, flag: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign nv   = r_q.nv;
    assign flag = r_q.flag;

endmodule

// File: rtl/stat_guard_dec.sv
module stat_guard_dec #(
    parameter int ADDR_W  = 12,
    parameter int CNT_W   = 16,
    parameter int PERIOD0 = 1400,
    parameter int PERIOD1 = 600,
    parameter int PERIOD2 = 200
) (
    input  logic [1:0]        bl,
    input  logic [1:0]        wd,
    output logic              prot_en,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi,
    output logic              wdog_off,
    output logic [CNT_W-1:0]  wdog_limit
);

    localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
    localparam logic [ADDR_W-1:0] HALF_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] QTR3_ADDR = {2'b11, {(ADDR_W-2){1'b0}}};
    localparam logic [CNT_W-1:0]  LIM0 = CNT_W'(PERIOD0);
    localparam logic [CNT_W-1:0]  LIM1 = CNT_W'(PERIOD1);
    localparam logic [CNT_W-1:0]  LIM2 = CNT_W'(PERIOD2);

    always_comb begin
        prot_en = 1'b1;
        prot_hi = TOP_ADDR;
        case (bl)
            2'b01:   prot_lo = QTR3_ADDR;
            2'b10:   prot_lo = HALF_ADDR;
            2'b11:   prot_lo = '0;
            default: begin
                prot_en = 1'b0;
                prot_lo = '0;
                prot_hi = '0;
            end
        endcase
    end

    always_comb begin
        wdog_off = 1'b0;
        case (wd)
            2'b00:   wdog_limit = LIM0;
            2'b01:   wdog_limit = LIM1;
            2'b10:   wdog_limit = LIM2;
            default: begin
                wdog_off   = 1'b1;
                wdog_limit = '0;
            end
        endcase
    end

endmodule

// File: rtl/stat_guard.sv
module stat_guard
    import stat_guard_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int CNT_W   = 16,
    parameter int PERIOD0 = 1400,
    parameter int PERIOD1 = 600,
    parameter int PERIOD2 = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren,
    input  logic              sr_wr,
    input  logic [7:0]        sr_wdata,
    input  logic              flag_set,
    input  logic              flag_clr,
    input  logic              wp_n,
    input  logic              nv_busy,
    output logic [7:0]        sr_value,
    output logic              wel,
    output logic              prot_en,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi,
    output logic [1:0]        wdog_code,
    output logic              wdog_off,
    output logic [CNT_W-1:0]  wdog_limit
);

    nv_fields_t nv_cur;
    nv_fields_t nv_stage;
    nv_fields_t wr_fields;
    logic       flag_q;
    logic       wel_q;
    logic       pend;
    logic       seen;
    logic       commit;

    assign wr_fields = nv_from_byte(sr_wdata);

    stat_guard_wrctl u_wrctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wren      (wren),
        .sr_wr     (sr_wr),
        .wr_fields (wr_fields),
        .wr_low    (sr_wdata[1:0]),
        .wp_n      (wp_n),
        .nv_busy   (nv_busy),
        .cur_wpen  (nv_cur.wpen),
        .wel       (wel_q),
        .pend      (pend),
        .seen      (seen),
        .commit    (commit),
        .stage     (nv_stage)
    );

    stat_guard_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .stage    (nv_stage),
        .flag_set (flag_set),
        .flag_clr (flag_clr),
        .nv       (nv_cur),
        .flag     (flag_q)
    );

    stat_guard_dec #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .PERIOD0 (PERIOD0),
        .PERIOD1 (PERIOD1),
        .PERIOD2 (PERIOD2)
    ) u_dec (
        .bl         (nv_cur.bl),
        .wd         (nv_cur.wd),
        .prot_en    (prot_en),
        .prot_lo    (prot_lo),
        .prot_hi    (prot_hi),
        .wdog_off   (wdog_off),
        .wdog_limit (wdog_limit)
    );

    assign sr_value  = sr_pack(nv_cur, flag_q, wel_q, pend || nv_busy);
    assign wel       = wel_q;
    assign wdog_code = nv_cur.wd;

endmodule

// File: rtl/stat_guard_chk.sv
module stat_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wren,
    input logic       sr_wr,
    input logic [7:0] sr_wdata,
    input logic       flag_set,
    input logic       flag_clr,
    input logic       wp_n,
    input logic       nv_busy,
    input logic [7:0] sr_value,
    input logic       wel,
    input logic [1:0] wdog_code,
    input logic       wdog_off,
    input logic       pend,
    input logic       seen
);

    // R2
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |=> !wel);

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wren && !sr_wr) |=> wel);

    // R4
    lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && !wp_n && sr_value[7] && !pend) |=> !pend);

    // R7
    low_bits_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && (sr_wdata[1:0] != 2'b00) && !pend) |=> !pend);

    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && nv_busy && !pend) |=> !pend);

    // R3
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend && seen && !nv_busy) |=> $stable({sr_value[7], sr_value[5:2]}));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !sr_value[6]);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set && !flag_clr) |=> sr_value[6]);

    // R9
    flag_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && sr_wdata[6] && !flag_set && !sr_value[6]) |=> !sr_value[6]);

    // R12
    wip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend || nv_busy) |-> sr_value[0]);

    // R11
    wdog_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_off |-> (wdog_code == 2'b11 && sr_value[5:4] == 2'b11));

endmodule

bind stat_guard stat_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wren      (wren),
    .sr_wr     (sr_wr),
    .sr_wdata  (sr_wdata),
    .flag_set  (flag_set),
    .flag_clr  (flag_clr),
    .wp_n      (wp_n),
    .nv_busy   (nv_busy),
    .sr_value  (sr_value),
    .wel       (wel),
    .wdog_code (wdog_code),
    .wdog_off  (wdog_off),
    .pend      (pend),
    .seen      (seen)
);

// File: tb/stat_guard_bench.sv
module stat_guard_bench;

    localparam int AW = 10;
    localparam int CW = 8;
    localparam int P0 = 140;
    localparam int P1 = 60;
    localparam int P2 = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wren = 1'b0;
    logic          sr_wr = 1'b0;
    logic [7:0]    sr_wdata = 8'h00;
    logic          flag_set = 1'b0;
    logic          flag_clr = 1'b0;
    logic          wp_n = 1'b1;
    logic          nv_busy = 1'b0;
    logic [7:0]    sr_value;
    logic          wel;
    logic          prot_en;
    logic [AW-1:0] prot_lo;
    logic [AW-1:0] prot_hi;
    logic [1:0]    wdog_code;
    logic          wdog_off;
    logic [CW-1:0] wdog_limit;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // reference state
    logic       m_wpen, m_flag, m_wel, m_pend, m_seen;
    logic [1:0] m_wd, m_bl;
    logic [7:0] m_stage;

    always #5 clk = ~clk;

    stat_guard #(
        .ADDR_W(AW), .CNT_W(CW), .PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2)
    ) u_stat_guard (
        .clk(clk), .rst_n(rst_n), .wren(wren), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .flag_set(flag_set), .flag_clr(flag_clr), .wp_n(wp_n), .nv_busy(nv_busy),
        .sr_value(sr_value), .wel(wel), .prot_en(prot_en), .prot_lo(prot_lo),
        .prot_hi(prot_hi), .wdog_code(wdog_code), .wdog_off(wdog_off),
        .wdog_limit(wdog_limit)
    );

    function automatic logic [AW-1:0] exp_lo(input logic [1:0] bl);
        if (bl == 2'b01) return AW'(3 << (AW - 2));
        if (bl == 2'b10) return AW'(1 << (AW - 1));
        return '0;
    endfunction

    function automatic logic [AW-1:0] exp_hi(input logic [1:0] bl);
        return (bl == 2'b00) ? '0 : AW'((1 << AW) - 1);
    endfunction

    function automatic logic [CW-1:0] exp_limit(input logic [1:0] wd);
        case (wd)
            2'b00:   return CW'(P0);
            2'b01:   return CW'(P1);
            2'b10:   return CW'(P2);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // reference model, evaluated on the same edge with stable inputs
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wpen = 1'b0; m_flag = 1'b0; m_wel = 1'b0; m_pend = 1'b0; m_seen = 1'b0;
            m_wd = 2'b11; m_bl = 2'b00; m_stage = 8'h00;
        end else begin
            logic acc, fin, n_wel, n_pend, n_seen, n_flag;
            acc = sr_wr && m_wel && !nv_busy && !m_pend && !(!wp_n && m_wpen)
                  && (sr_wdata[1:0] == 2'b00);
            fin = m_pend && m_seen && !nv_busy;
            n_wel  = sr_wr ? 1'b0 : (wren ? 1'b1 : m_wel);
            n_flag = flag_clr ? 1'b0 : (flag_set ? 1'b1 : m_flag);
            n_pend = m_pend; n_seen = m_seen;
            if (acc) begin
                n_pend = 1'b1; n_seen = 1'b0; m_stage = sr_wdata;
            end else if (fin) begin
                n_pend = 1'b0; n_seen = 1'b0;
                m_wpen = m_stage[7]; m_wd = m_stage[5:4]; m_bl = m_stage[3:2];
            end else if (m_pend && nv_busy) begin
                n_seen = 1'b1;
            end
            m_wel = n_wel; m_pend = n_pend; m_seen = n_seen; m_flag = n_flag;
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sr_value[7] == m_wpen && sr_value[5:2] == {m_wd, m_bl}, "R3 fields",
                sr_value, {m_wpen, 1'b0, m_wd, m_bl, 2'b00});
            chk(sr_value[6] == m_flag, "R9 flag", sr_value[6], m_flag);
            chk(wel == m_wel && sr_value[1] == m_wel, "R2 wel", wel, m_wel);
            chk(sr_value[0] == (m_pend || nv_busy), "R12 wip", sr_value[0], m_pend || nv_busy);
            chk(prot_en == (m_bl != 2'b00) && prot_lo == exp_lo(m_bl) && prot_hi == exp_hi(m_bl),
                "R10 range", {prot_en, prot_lo, prot_hi}, {m_bl != 2'b00, exp_lo(m_bl), exp_hi(m_bl)});
            chk(wdog_code == m_wd && wdog_off == (m_wd == 2'b11) && wdog_limit == exp_limit(m_wd),
                "R11 watchdog", {wdog_off, wdog_code, wdog_limit}, {m_wd == 2'b11, m_wd, exp_limit(m_wd)});
        end
    end

    task automatic do_write(input logic [7:0] data);
        wren = 1'b1; tick(); wren = 1'b0;
        sr_wr = 1'b1; sr_wdata = data; tick(); sr_wr = 1'b0;
    endtask

    task automatic nv_cycle(input int n);
        nv_busy = 1'b1;
        repeat (n) tick();
        nv_busy = 1'b0;
        tick();
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED);
        repeat (3) tick();
        @(negedge clk);
        // R1 reset values
        chk(sr_value == 8'h30 && !wel && !prot_en && wdog_off, "R1 reset", sr_value, 8'h30);
        rst_n = 1'b1;
        tick();

        // R3 R10 R11: plain accepted write, half the space locked, longest period
        do_write(8'h08); nv_cycle(2);
        @(negedge clk);
        chk(sr_value[7:2] == 6'b000010, "R3 accept", sr_value, 8'h08);
        chk(prot_lo == AW'(10'h200), "R10 half", prot_lo, 10'h200);
        chk(wdog_limit == CW'(P0), "R11 period", wdog_limit, P0);

        // R5: pin low, protect-enable clear, write accepted (sets protect-enable)
        wp_n = 1'b0; tick();
        do_write(8'h8C); nv_cycle(2);
        @(negedge clk);
        chk(sr_value[7:2] == 6'b100011, "R5 pin ignored", sr_value, 8'h8C);

        // R4: now locked, write refused, latch still cleared
        do_write(8'h30); nv_cycle(2);
        @(negedge clk);
        chk(sr_value[7:2] == 6'b100011, "R4 locked", sr_value, 8'h8C);
        chk(!wel, "R2 cleared on refused write", wel, 0);

        // R6: pin high, write accepted, pin drops during programming
        wp_n = 1'b1; tick();
        do_write(8'hB4);
        wp_n = 1'b0;
        nv_cycle(3);
        @(negedge clk);
        chk(sr_value[7:2] == 6'b101101, "R6 completes", sr_value, 8'hB4);
        do_write(8'h80); nv_cycle(2);
        @(negedge clk);
        chk(sr_value[7:2] == 6'b101101, "R4 relock", sr_value, 8'hB4);

        // R7: low data bits nonzero
        wp_n = 1'b1; tick();
        do_write(8'h01); nv_cycle(2);
        @(negedge clk);
        chk(sr_value[7:2] == 6'b101101, "R7 low bits", sr_value, 8'hB4);

        // R8: write during external busy
        nv_busy = 1'b1;
        do_write(8'h00);
        nv_busy = 1'b0; tick(); tick();
        @(negedge clk);
        chk(sr_value[7:2] == 6'b101101 && !sr_value[0], "R8 busy", sr_value, 8'hB4);

        // R9: flag set, clear priority, write data bit 6 ignored
        flag_set = 1'b1; tick(); flag_set = 1'b0;
        @(negedge clk);
        chk(sr_value[6], "R9 set", sr_value[6], 1);
        flag_set = 1'b1; flag_clr = 1'b1; tick(); flag_set = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        chk(!sr_value[6], "R9 clear wins", sr_value[6], 0);
        do_write(8'h40); nv_cycle(2);
        @(negedge clk);
        chk(!sr_value[6] && sr_value[7:2] == 6'b000000, "R9 write ignores flag", sr_value, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            wren     = ($urandom % 100) < 35;
            sr_wr    = ($urandom % 100) < 25;
            sr_wdata = 8'($urandom);
            if (($urandom % 100) < 80) sr_wdata[1:0] = 2'b00;
            if (($urandom % 100) < 15) wp_n = ~wp_n;
            if (($urandom % 100) < 25) nv_busy = ~nv_busy;
            flag_set = ($urandom % 100) < 8;
            flag_clr = ($urandom % 100) < 8;
            tick();
        end

        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL all watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule